// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a periodic interrupt from the processor clock. A prescaler divides the clock by a programmable scale value. Each prescaled tick steps a down-counter by one. When a tick finds the counter at zero, the counter reloads itself from a period register and the block emits a one-cycle interrupt pulse. Software writes the count, the period and the scale through a small register port and can read each one back. A single enable input starts and freezes the timer.

The control path is a two-state machine. In `ST_HALT` the timer is frozen. The `arm` transition (HALT to RUN, taken when `en` is high) spends its cycle restarting the prescaler and does not count. In `ST_RUN` the prescaler and counter advance on every cycle in which `en` is high. The `stop` transition (RUN to HALT, taken when `en` is low) freezes the timer again. Writes act in both states. With scale S and period P, the interrupt repeats every (S+1)·(P+1) enabled cycles.

Top module: `intv_timer`

## Requirements
- R1: After reset the count, period and scale registers read as zero, `irq` is low and the machine is in `ST_HALT`.
- R2: `wr_sel`/`rd_sel` encoding: 0 = count, 1 = period, 2 = scale, 3 = none. Reading code 3 returns zero. The scale register keeps only `wr_data[7:0]` and reads back zero-extended. Reads are combinational from the current register values.
- R3: With scale value S, the counter takes one prescaled tick every S+1 enabled running cycles, so S = 0 gives a tick on every enabled cycle.
- R4: On a tick, a nonzero count decrements by one. A zero count instead reloads from the period register value held before that edge.
- R5: `irq` is high for exactly the cycle after each reload edge, which is the cycle in which the count first shows the reloaded value. With a period of zero, every tick produces a pulse.
- R6: While `en` is low, the count and the prescaler do not advance and `irq` stays low. Register writes still take effect.
- R7: The cycle in which `en` is first seen high (the `arm` transition) restarts the prescaler and produces no tick. The first tick comes S+1 enabled cycles later.
- R8: A count write takes effect on the following cycle. It overrides any tick in the same cycle and restarts the prescale interval.
- R9: A scale write restarts the prescale interval with the newly written value. No tick occurs in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Timer enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes (R2 encoding) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads (R2 encoding) |
| rd_data | output | 16 | Read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps scale, period and initial count over small ranges and computes, for every enabled cycle, the count that must be visible and whether `irq` must pulse. This catches an off-by-one in the prescale divide, a reload one tick early or late, and a zero period that stalls instead of firing on every tick. Further sequences target the restart rules:
- Freezing and re-enabling the timer exposes a design that keeps counting while disabled or that ticks in the arm cycle.
- A count write in the middle of a prescale interval exposes a design that finishes the old interval rather than restarting it.
- A scale write exposes a design that ticks in the write cycle or keeps the old divide.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/intv_timer_ctrl.sv
module intv_timer_ctrl
    import intv_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic arm,
    output logic run
);
    run_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state: arm (HALT->RUN), stop (RUN->HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        arm = 1'b0;
        run = 1'b0;
        unique case (state_q)
            ST_HALT: arm = en;
            ST_RUN:  run = en;
            default: ;
        endcase
    end
endmodule

// File: rtl/intv_timer_prescale.sv
module intv_timer_prescale #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SCALE_W-1:0] load_val,
    input  logic [SCALE_W-1:0] scale_val,
    input  logic               run,
    output logic               tick,
    output logic [SCALE_W-1:0] pre_q
);
    localparam logic [SCALE_W-1:0] PRE_ZERO = '0;

    assign tick = run && !restart && (pre_q == PRE_ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= PRE_ZERO;
        end else if (restart) begin
            pre_q <= load_val;
        end else if (run) begin
            if (pre_q == PRE_ZERO) pre_q <= scale_val;
            else                   pre_q <= pre_q - 1'b1;
        end
    end
endmodule

// File: rtl/intv_timer_count.sv
module intv_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic at_zero;
    assign at_zero = (cnt_q == CNT_ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
            irq_q <= 1'b0;
        end else begin
            irq_q <= tick && at_zero && !load;
            if (load)
                cnt_q <= load_val;
            else if (tick)
                cnt_q <= at_zero ? period : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/intv_timer_cfg.sv
module intv_timer_cfg
    import intv_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [1:0]         rd_sel,
    input  logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   period_q,
    output logic [SCALE_W-1:0] scale_q,
    output logic [CNT_W-1:0]   rd_data
);
    localparam int PAD_W = CNT_W - SCALE_W;

    reg_sel_e wsel, rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            scale_q  <= '0;
        end else if (wr_en) begin
            if (wsel == SEL_PERIOD) period_q <= wr_data;
            if (wsel == SEL_SCALE)  scale_q  <= wr_data[SCALE_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_COUNT:  rd_data = cnt;
            SEL_PERIOD: rd_data = period_q;
            SEL_SCALE:  rd_data = {{PAD_W{1'b0}}, scale_q};
            SEL_NONE:   rd_data = '0;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    logic               arm, run, tick, restart, wr_cnt, wr_scl;
    logic [SCALE_W-1:0] scale_q, pre_q, pre_load;
    logic [CNT_W-1:0]   period_q, cnt_q;

    assign wr_cnt   = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
    assign wr_scl   = wr_en && (reg_sel_e'(wr_sel) == SEL_SCALE);
    assign restart  = arm || wr_cnt || wr_scl;
    assign pre_load = wr_scl ? wr_data[SCALE_W-1:0] : scale_q;

    intv_timer_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .arm(arm), .run(run)
    );

    intv_timer_cfg #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .cnt(cnt_q),
        .period_q(period_q), .scale_q(scale_q), .rd_data(rd_data)
    );

    intv_timer_prescale #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart), .load_val(pre_load),
        .scale_val(scale_q), .run(run), .tick(tick), .pre_q(pre_q)
    );

    intv_timer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(wr_data),
        .tick(tick), .period(period_q), .cnt_q(cnt_q), .irq_q(irq)
    );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [CNT_W-1:0]   wr_data,
    input logic               irq,
    input logic               tick,
    input logic               arm,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [CNT_W-1:0]   period_q,
    input logic [SCALE_W-1:0] scale_q,
    input logic [SCALE_W-1:0] pre_q
);
    p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= scale_q);

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0) |=> (cnt_q == $past(period_q)));

    p_irq_on_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0) |=> irq);

    p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);

    p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> $stable(cnt_q));

    p_no_tick_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !tick);

    p_count_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (cnt_q == $past(wr_data)));
endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq(irq), .tick(tick), .arm(arm), .cnt_q(cnt_q),
    .period_q(period_q), .scale_q(scale_q), .pre_q(pre_q)
);

// File: tb/intv_timer_tb.sv
module intv_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intv_timer u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // called at a negedge, returns at the negedge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic config_timer(input int s, input int p, input int c);
        en = 1'b0;
        step();
        wr(2'd2, 16'(s));
        wr(2'd1, 16'(p));
        wr(2'd0, 16'(c));
    endtask

    // enable: returns at the negedge after the arm edge
    task automatic start();
        en = 1'b1;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1 chk("R1 reset value", int'(rd_data), 0);
        end
        chk("R1 irq after reset", int'(irq), 0);

        // R2: register encodings and readback
        wr(2'd1, 16'hBEEF);
        wr(2'd2, 16'h12A5);
        rd_sel = 2'd1; #1 chk("R2 period read", int'(rd_data), 16'hBEEF);
        rd_sel = 2'd2; #1 chk("R2 scale zero-extended", int'(rd_data), 16'h00A5);
        rd_sel = 2'd3; #1 chk("R2 code 3 reads zero", int'(rd_data), 0);
        rd_sel = 2'd0; #1 chk("R2 count untouched", int'(rd_data), 0);

        // R3 R4 R5 R7: sweep scale, period, initial count
        for (int s = 0; s < 3; s++)
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 3; c++) begin
                    config_timer(s, p, c);
                    chk("R6 irq low while off", int'(irq), 0);
                    start();
                    chk("R7 no tick in arm cycle", int'(rd_data), c);
                    for (int k = 1; k <= (s + 1) * 12; k++) begin
                        int j, ec, ei;
                        step();
                        j = k / (s + 1);
                        if (j <= c) ec = c - j;
                        else        ec = p - ((j - c - 1) % (p + 1));
                        ei = ((k % (s + 1)) == 0 && j >= c + 1 &&
                              ((j - c - 1) % (p + 1)) == 0) ? 1 : 0;
                        chk("R3 R4 count sequence", int'(rd_data), ec);
                        chk("R5 irq pulse", int'(irq), ei);
                    end
                    en = 1'b0;
                end

        // R6: freeze and resume
        config_timer(1, 5, 4);
        start();
        repeat (4) step();
        chk("R3 count before freeze", int'(rd_data), 2);
        en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R6 count held", int'(rd_data), 2);
            chk("R6 no irq when off", int'(irq), 0);
        end
        start();
        chk("R7 arm cycle holds count", int'(rd_data), 2);
        step();
        chk("R7 no tick one cycle after arm", int'(rd_data), 2);
        step();
        chk("R7 first tick after S+1", int'(rd_data), 1);
        en = 1'b0;

        // R8: count write restarts prescale interval
        config_timer(3, 7, 9);
        start();
        repeat (6) step();
        chk("R3 count before write", int'(rd_data), 8);
        wr(2'd0, 16'd5);
        chk("R8 count written", int'(rd_data), 5);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 interval restarted", int'(rd_data), 5);
        end
        step();
        chk("R8 tick after full interval", int'(rd_data), 4);
        en = 1'b0;

        // R9: scale write restarts with new value
        config_timer(0, 9, 9);
        start();
        repeat (2) step();
        chk("R3 scale zero every cycle", int'(rd_data), 7);
        wr(2'd2, 16'd2);
        chk("R9 no tick in write cycle", int'(rd_data), 7);
        for (int i = 0; i < 2; i++) begin
            step();
            chk("R9 new interval running", int'(rd_data), 7);
        end
        step();
        chk("R9 tick at new scale", int'(rd_data), 6);
        rd_sel = 2'd2; #1 chk("R9 scale readback", int'(rd_data), 2);
        rd_sel = 2'd0;
        en = 1'b0;
        step();

        finish_run();
    end
endmodule